// File: doc/BRIEF.md
# Tagged Floating-Point Register Stack

This block holds eight 80-bit floating-point registers arranged as a stack. Every register is addressed relative to a 3-bit top-of-stack pointer, so the entry named ST(i) is the physical register at (top + i) mod 8. Each physical register has a one-bit tag that says whether it holds a live value (1) or is empty (0). An arithmetic unit reads ST(0) and one other ST(i) at the same time. It pushes a new value, and after a compare it retires one or two values.

A pop never moves data. It clears the tag of the current top register and steps the pointer forward. A double pop clears the tags of ST(0) and ST(1) and advances the pointer by two in a single command. The block flags every empty entry that is read, so that the arithmetic unit can raise a stack fault and an invalid-operation condition. It also flags a push that lands on an entry that is still live.

Top module: `fp_reg_stack`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `top_o` is 0 and all eight bits of `tag_o` are 0 (every entry empty). Bit k of `tag_o` is the tag of physical register k, and 1 means valid.
- R2: `st0_val` returns physical register `top_o`, and `sti_val` returns physical register (`top_o` + `sel_i`) mod 8. Both are combinational and follow `sel_i` in the same cycle.
- R3: `st0_empty` and `sti_empty` are 1 exactly when the tag of the physical register read by `st0_val` or `sti_val` respectively is 0.
- R4: A push (`push_en`=1) moves `top_o` to (`top_o` − 1) mod 8 at the next edge. It writes `push_val` into that register and sets its tag, so that after the edge the new value is ST(0) and the old ST(i) reads as ST(i+1).
- R5: `push_ovf` is combinational. It is 1 exactly when `push_en` is 1 and the tag of register (`top_o` − 1) mod 8 is already set. The push still overwrites that register.
- R6: A single pop (`pop_cnt`=2'b01, no push) clears the tag at `top_o` and moves `top_o` to (`top_o` + 1) mod 8. No register data changes.
- R7: A double pop (`pop_cnt`=2'b10 or 2'b11, no push) clears the tags at `top_o` and (`top_o` + 1) mod 8 in the same edge, and moves `top_o` to (`top_o` + 2) mod 8.
- R8: When `push_en` is 1, `pop_cnt` is ignored and only the push takes effect.
- R9: With `push_en`=0 and `pop_cnt`=2'b00, `top_o`, `tag_o` and the register contents hold.
- R10: A push onto an empty entry followed by a single pop leaves `top_o` and `tag_o` exactly as they were before the push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| push_en | input | 1 | Push `push_val` onto the stack |
| push_val | input | 80 | Value to push |
| pop_cnt | input | 2 | 00 none, 01 single pop, 1x double pop |
| sel_i | input | 3 | Stack index i for the second read port |
| top_o | output | 3 | Current top-of-stack pointer |
| tag_o | output | 8 | Per physical register tag, 1 = valid |
| st0_val | output | 80 | Contents of ST(0) |
| st0_empty | output | 1 | ST(0) is empty |
| sti_val | output | 80 | Contents of ST(sel_i) |
| sti_empty | output | 1 | ST(sel_i) is empty |
| push_ovf | output | 1 | Current push targets a valid entry |

## Verification
The read ports, the empty flags and `push_ovf` are combinational. The bench therefore checks them in the same cycle as the stimulus: `push_ovf` is sampled a short delay after the push is driven at the falling edge, and each `sel_i` value is settled for a short delay before `sti_val` is compared. A push or pop changes the pointer, the tags and the data on exactly one rising edge. The bench samples these shortly after that edge and then sweeps all eight ST(i) against a model that is updated from the requirements. The R10 check compares the pointer and the tags taken before the push with those taken after the following pop, two edges later.

// File: rtl/fp_reg_stack.sv
module fp_reg_stack #(
  parameter int DW    = 80,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [DW-1:0]    push_val,
  input  logic [1:0]       pop_cnt,
  input  logic [PW-1:0]    sel_i,
  output logic [PW-1:0]    top_o,
  output logic [DEPTH-1:0] tag_o,
  output logic [DW-1:0]    st0_val,
  output logic             st0_empty,
  output logic [DW-1:0]    sti_val,
  output logic             sti_empty,
  output logic             push_ovf
);

  logic [DW-1:0]    regs [DEPTH];
  logic [PW-1:0]    top;
  logic [DEPTH-1:0] tags;

  logic [PW-1:0] top_dn, top_up1, top_up2, phys_i;
  assign top_dn  = top - PW'(1);
  assign top_up1 = top + PW'(1);
  assign top_up2 = top + PW'(2);
  assign phys_i  = top + sel_i;

  assign top_o     = top;
  assign tag_o     = tags;
  assign st0_val   = regs[top];
  assign st0_empty = ~tags[top];
  assign sti_val   = regs[phys_i];
  assign sti_empty = ~tags[phys_i];
  assign push_ovf  = push_en & tags[top_dn];

  always_ff @(posedge clk) begin
    if (push_en) regs[top_dn] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top  <= '0;
      tags <= '0;
    end else if (push_en) begin
      tags[top_dn] <= 1'b1;
      top          <= top_dn;
    end else if (pop_cnt[1]) begin
      tags[top]     <= 1'b0;
      tags[top_up1] <= 1'b0;
      top           <= top_up2;
    end else if (pop_cnt[0]) begin
      tags[top] <= 1'b0;
      top       <= top_up1;
    end
  end

endmodule

// File: rtl/fp_reg_stack_chk.sv
module fp_reg_stack_chk #(
  parameter int DW    = 80,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_en,
  input logic [DW-1:0]    push_val,
  input logic [1:0]       pop_cnt,
  input logic [PW-1:0]    top_o,
  input logic [DEPTH-1:0] tag_o,
  input logic [DW-1:0]    st0_val,
  input logic             push_ovf
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (top_o == '0 && tag_o == '0));

  // R4
  push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> (top_o == PW'($past(top_o) - 1'b1) && tag_o[top_o] && st0_val == $past(push_val)));

  // R5
  ovf_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && push_ovf) |=> ($countones(tag_o) == $past($countones(tag_o))));

  // R5
  fresh_push_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !push_ovf) |=> ($countones(tag_o) == $past($countones(tag_o)) + 1));

  // R6
  single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_en && pop_cnt == 2'b01) |=> (top_o == PW'($past(top_o) + 1'b1) && !tag_o[$past(top_o)]));

  // R7
  double_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_en && pop_cnt[1]) |=> (top_o == PW'($past(top_o) + 2'd2)
      && !tag_o[$past(top_o)] && !tag_o[PW'($past(top_o) + 1'b1)]));

  // R8
  push_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && pop_cnt != 2'b00) |=> (top_o == PW'($past(top_o) - 1'b1)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_en && pop_cnt == 2'b00) |=> ($stable(top_o) && $stable(tag_o)));

endmodule

bind fp_reg_stack fp_reg_stack_chk #(.DW(DW), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_val(push_val),
  .pop_cnt(pop_cnt), .top_o(top_o), .tag_o(tag_o), .st0_val(st0_val),
  .push_ovf(push_ovf)
);

// File: tb/fp_reg_stack_tb.sv
`timescale 1ns/100ps
module fp_reg_stack_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_en = 1'b0;
  logic [79:0] push_val = '0;
  logic [1:0]  pop_cnt = 2'b00;
  logic [2:0]  sel_i = '0;
  logic [2:0]  top_o;
  logic [7:0]  tag_o;
  logic [79:0] st0_val, sti_val;
  logic        st0_empty, sti_empty, push_ovf;

  fp_reg_stack dut_i (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_val(push_val),
    .pop_cnt(pop_cnt), .sel_i(sel_i), .top_o(top_o), .tag_o(tag_o),
    .st0_val(st0_val), .st0_empty(st0_empty), .sti_val(sti_val),
    .sti_empty(sti_empty), .push_ovf(push_ovf)
  );

  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int mtop = 0;
  bit mtag [8];
  bit mknown [8];
  logic [79:0] mdata [8];

  task automatic chk(input bit ok, input string rq, input logic [79:0] act, input logic [79:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] mtags();
    logic [7:0] t;
    for (int k = 0; k < 8; k++) t[k] = mtag[k];
    return t;
  endfunction

  task automatic sweep(input string rq);
    chk(top_o == 3'(mtop), {rq, " top"}, 80'(top_o), 80'(mtop));
    chk(tag_o == mtags(), {rq, " tags"}, 80'(tag_o), 80'(mtags()));
    chk(st0_empty == !mtag[mtop], "R3 st0_empty", 80'(st0_empty), 80'(!mtag[mtop]));
    if (mknown[mtop]) chk(st0_val == mdata[mtop], "R2 st0_val", st0_val, mdata[mtop]);
    for (int i = 0; i < 8; i++) begin
      int ph;
      sel_i = 3'(i);
      #0.1;
      ph = (mtop + i) % 8;
      chk(sti_empty == !mtag[ph], "R3 sti_empty", 80'(sti_empty), 80'(!mtag[ph]));
      if (mknown[ph]) chk(sti_val == mdata[ph], "R2 sti_val", sti_val, mdata[ph]);
    end
  endtask

  task automatic op(input bit p, input logic [79:0] v, input logic [1:0] pc, input string rq);
    bit eo;
    @(negedge clk);
    push_en = p; push_val = v; pop_cnt = pc;
    #0.1;
    eo = p && mtag[(mtop + 7) % 8];
    chk(push_ovf == eo, "R5 push_ovf", 80'(push_ovf), 80'(eo));
    @(posedge clk);
    #0.1;
    push_en = 1'b0; pop_cnt = 2'b00;
    if (p) begin
      mtop = (mtop + 7) % 8;
      mdata[mtop] = v; mknown[mtop] = 1'b1; mtag[mtop] = 1'b1;
    end else if (pc[1]) begin
      mtag[mtop] = 1'b0; mtag[(mtop + 1) % 8] = 1'b0; mtop = (mtop + 2) % 8;
    end else if (pc[0]) begin
      mtag[mtop] = 1'b0; mtop = (mtop + 1) % 8;
    end
    sweep(rq);
  endtask

  function automatic logic [79:0] val(input int k);
    return {16'(16'h3FF0 + k), 64'(64'h0123_4567_89AB_CDEF * (k + 3))};
  endfunction

  initial begin
    #1_000_000;
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lf;
    logic [2:0] t0;
    logic [7:0] g0;
    for (int k = 0; k < 8; k++) begin mtag[k] = 0; mknown[k] = 0; mdata[k] = '0; end
    repeat (3) @(posedge clk);
    #0.1;
    sweep("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #0.1;
    sweep("R1 after reset");

    for (int k = 0; k < 8; k++) op(1'b1, val(k), 2'b00, "R4 fill");
    op(1'b1, val(8), 2'b00, "R5 overflow push");
    op(1'b0, '0, 2'b00, "R9 idle");
    op(1'b0, '0, 2'b01, "R6 pop");
    op(1'b0, '0, 2'b01, "R6 pop");
    op(1'b1, val(9), 2'b01, "R8 push beats pop");
    op(1'b1, val(10), 2'b10, "R8 push beats double");
    op(1'b0, '0, 2'b10, "R7 double pop");
    op(1'b0, '0, 2'b11, "R7 double pop 11");
    op(1'b0, '0, 2'b10, "R7 double pop");

    t0 = top_o; g0 = tag_o;
    op(1'b1, val(11), 2'b00, "R10 push");
    op(1'b0, '0, 2'b01, "R10 pop");
    chk(top_o == t0, "R10 top restored", 80'(top_o), 80'(t0));
    chk(tag_o == g0, "R10 tags restored", 80'(tag_o), 80'(g0));

    for (int k = 0; k < 6; k++) op(1'b0, '0, 2'b10, "R7 wrap on empty");
    op(1'b0, '0, 2'b01, "R6 pop empty");

    lf = 32'h1D;
    for (int n = 0; n < 300; n++) begin
      lf = ((lf << 1) | (((lf >> 6) ^ (lf >> 5)) & 1)) & 8'h7F;
      case (lf % 5)
        0, 1: op(1'b1, val(100 + n), 2'(lf >> 3), "R4 mixed push");
        2:    op(1'b0, '0, 2'b01, "R6 mixed pop");
        3:    op(1'b0, '0, 2'b10, "R7 mixed double");
        default: op(1'b0, '0, 2'b00, "R9 mixed idle");
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule